// File: doc/BRIEF.md
# Bus Region Decoder with RAM Store Guard

This block sits on a 32-bit processor bus and sorts each access into one of four target regions by the top half of its address. The regions are main RAM with two mirror windows, boot ROM with two mirror windows, a single I/O page, and a cache/bus-unit control page. Any other page is unmapped. The region select is combinational. It is gated by the read and write strobes. An access to an unmapped page raises a flag for the cycle of the strobe, and its write is dropped. The memory arrays, the ROM contents and the I/O devices downstream are not part of this block.

The block also holds one guard bit. When the guard is set, word-sized stores to the lowest RAM page do not reach RAM. A boot-time memory test uses this. A word store to one fixed address in the control page sets or clears the guard, depending on the value written. A store with any other value leaves the guard as it is.

Top module: `addr_map_guard`

## Requirements
- R1: The page index is `addr[31:16]`. When `rd` or `wr` is high, `sel` has exactly one bit set for a mapped page, using this encoding: bit0 RAM, bit1 ROM, bit2 I/O, bit3 control. When neither strobe is high, `sel` is 0 and `unmapped` is 0.
- R2: Pages 0x0000–0x001F, 0x8000–0x801F and 0xA000–0xA01F select RAM. A write there raises `ram_we`, except in the case R8 describes.
- R3: Pages 0x1FC0–0x1FC7, 0x9FC0–0x9FC7 and 0xBFC0–0xBFC7 select ROM for all three sizes. A write to ROM never raises `ram_we`.
- R4: Page 0x1F80 selects I/O for reads and writes of all three sizes.
- R5: Page 0xFFFE selects the control page. The access size is encoded as 2'b00 = byte, 2'b01 = half, 2'b10 = word. A control-page store changes the guard only when `size` is 2'b10 and `addr` is exactly 0xFFFE0130.
- R6: A qualifying store of 0x800 or 0x804 sets the guard on the clock edge that samples the store.
- R7: A qualifying store of 0x0 or 0x1E988 clears the guard. Any other value leaves the guard unchanged.
- R8: While the guard is set, a word write to page 0x0000 leaves `ram_we` low. Byte and half writes to that page, and word writes to other RAM pages or mirrors, still raise `ram_we`.
- R9: Reset clears the guard.
- R10: A strobe to an unmapped page raises `unmapped` for that cycle. In that cycle `sel` is 0 and `ram_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 32 | Bus address |
| wdata | input | 32 | Write data |
| size | input | 2 | Access size: 00 = byte, 01 = half, 10 = word |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| sel | output | 4 | One-hot region select: RAM, ROM, I/O, control |
| ram_we | output | 1 | RAM write enable |
| unmapped | output | 1 | Strobe to an unmapped page |

## Verification
Several properties are checked on every cycle:
- `sel` and `unmapped` are never both set, and no region is selected without a strobe.
- `ram_we` only ever accompanies a RAM-selected write.
- A set value stored to the control address blocks a word store to page 0 in the next cycle.
- A clear value stored there lets such a store through in the next cycle.

Only the bench scenarios show the rest:
- the exact page boundaries of every mirror window;
- that stores with other values, other sizes or other addresses leave the guard untouched;
- that reset clears the guard.

// File: rtl/addr_map_guard.sv
module addr_map_guard #(
  parameter logic [31:0] GUARD_ADDR = 32'hFFFE0130
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic [1:0]  size,
  input  logic        rd,
  input  logic        wr,
  output logic [3:0]  sel,
  output logic        ram_we,
  output logic        unmapped
);
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [15:0] pg;
  logic        acc, in_ram, in_rom, in_io, in_ctl, word_wr, guard_hit, guard;

  assign pg  = addr[31:16];
  assign acc = rd | wr;

  assign in_ram = (pg[15:5] == 11'h000) || (pg[15:5] == 11'h400) || (pg[15:5] == 11'h500);
  assign in_rom = (pg[15:3] == 13'h03F8) || (pg[15:3] == 13'h13F8) || (pg[15:3] == 13'h17F8);
  assign in_io  = (pg == 16'h1F80);
  assign in_ctl = (pg == 16'hFFFE);

  assign sel      = acc ? {in_ctl, in_io, in_rom, in_ram} : 4'b0;
  assign unmapped = acc & ~(in_ram | in_rom | in_io | in_ctl);

  assign word_wr   = wr & (size == SZ_WORD);
  assign guard_hit = word_wr & (addr == GUARD_ADDR);
  assign ram_we    = wr & in_ram & ~(guard & word_wr & (pg == 16'h0000));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) guard <= 1'b0;
    else if (guard_hit)
      case (wdata)
        32'h0000_0800, 32'h0000_0804: guard <= 1'b1;
        32'h0000_0000, 32'h0001_E988: guard <= 1'b0;
        default: ;
      endcase
endmodule

// File: rtl/addr_map_guard_chk.sv
module addr_map_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] addr,
  input logic [31:0] wdata,
  input logic [1:0]  size,
  input logic        rd,
  input logic        wr,
  input logic [3:0]  sel,
  input logic        ram_we,
  input logic        unmapped
);
  logic ctl_st, page0_st;
  assign ctl_st   = wr && size == 2'b10 && addr == 32'hFFFE0130;
  assign page0_st = wr && size == 2'b10 && addr[31:16] == 16'h0000;

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel, unmapped}));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |-> (sel == 4'b0 && !unmapped));
  p_we_in_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr && sel[0]));
  p_rom_no_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel[1] |-> !ram_we);
  p_set_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_st && (wdata == 32'h800 || wdata == 32'h804)) |=> !(page0_st && ram_we));
  p_clear_allows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_st && (wdata == 32'h0 || wdata == 32'h1E988)) |=> (page0_st -> ram_we));
  p_unmapped_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (!ram_we && sel == 4'b0));
endmodule

bind addr_map_guard addr_map_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .size(size),
  .rd(rd), .wr(wr), .sel(sel), .ram_we(ram_we), .unmapped(unmapped)
);

// File: tb/sim_addr_map_guard.sv
module sim_addr_map_guard;
  logic clk = 0, rst_n = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic [1:0] size = 0;
  logic rd = 0, wr = 0;
  logic [3:0] sel;
  logic ram_we, unmapped;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  addr_map_guard u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .size(size),
    .rd(rd), .wr(wr), .sel(sel), .ram_we(ram_we), .unmapped(unmapped));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] d, logic [1:0] s, logic r, logic w);
    @(negedge clk);
    addr = a; wdata = d; size = s; rd = r; wr = w;
    #1;
  endtask

  task automatic ctl_store(logic [31:0] a, logic [31:0] d, logic [1:0] s);
    drive(a, d, s, 0, 1);
    @(posedge clk);
  endtask

  task automatic t_idle_and_reset;
    drive(32'h0, 0, 2, 0, 0);
    check("R1 idle sel", sel, 0);
    check("R1 idle unmapped", unmapped, 0);
    drive(32'h0000_0010, 0, 2, 0, 1);
    check("R9 guard clear after reset", ram_we, 1);
  endtask

  task automatic t_ram;
    logic [31:0] pages[6] = '{32'h0000_0000, 32'h001F_FFFC, 32'h8000_0000,
                               32'h801F_0000, 32'hA000_0004, 32'hA01F_FFF0};
    foreach (pages[i]) begin
      drive(pages[i], 0, 2, 1, 0);
      check("R2 ram sel", sel, 4'b0001);
      drive(pages[i], 0, 0, 0, 1);
      check("R2 ram we", ram_we, 1);
    end
    drive(32'h0020_0000, 0, 2, 1, 0);
    check("R10 past ram", unmapped, 1);
  endtask

  task automatic t_rom_io;
    logic [31:0] pages[6] = '{32'h1FC0_0000, 32'h1FC7_FFFC, 32'h9FC0_0100,
                               32'h9FC7_0000, 32'hBFC0_0000, 32'hBFC7_0002};
    foreach (pages[i]) for (int s = 0; s < 3; s++) begin
      drive(pages[i], 0, s[1:0], 1, 0);
      check("R3 rom sel", sel, 4'b0010);
    end
    drive(32'h1FC0_0000, 0, 2, 0, 1);
    check("R3 rom no we", ram_we, 0);
    drive(32'h1FC8_0000, 0, 2, 1, 0);
    check("R10 past rom", unmapped, 1);
    for (int s = 0; s < 3; s++) begin
      drive(32'h1F80_1070, 0, s[1:0], 1, 0);
      check("R4 io rd", sel, 4'b0100);
      drive(32'h1F80_1074, 0, s[1:0], 0, 1);
      check("R4 io wr", sel, 4'b0100);
      check("R4 io no we", ram_we, 0);
    end
    drive(32'hFFFE_0000, 0, 2, 1, 0);
    check("R5 ctl sel", sel, 4'b1000);
  endtask

  task automatic t_guard;
    ctl_store(32'hFFFE0130, 32'h800, 2);
    drive(32'h0000_0100, 0, 2, 0, 1);
    check("R6 set 800 blocks", ram_we, 0);
    drive(32'h0000_0100, 0, 0, 0, 1);
    check("R8 byte passes", ram_we, 1);
    drive(32'h0000_0100, 0, 1, 0, 1);
    check("R8 half passes", ram_we, 1);
    drive(32'h0001_0000, 0, 2, 0, 1);
    check("R8 page1 passes", ram_we, 1);
    drive(32'h8000_0100, 0, 2, 0, 1);
    check("R8 mirror passes", ram_we, 1);
    ctl_store(32'hFFFE0130, 32'h1234, 2);
    drive(32'h0000_0100, 0, 2, 0, 1);
    check("R7 other value keeps", ram_we, 0);
    ctl_store(32'hFFFE0134, 32'h0, 2);
    drive(32'h0000_0100, 0, 2, 0, 1);
    check("R5 other addr ignored", ram_we, 0);
    ctl_store(32'hFFFE0130, 32'h0, 1);
    drive(32'h0000_0100, 0, 2, 0, 1);
    check("R5 half size ignored", ram_we, 0);
    ctl_store(32'hFFFE0130, 32'h1E988, 2);
    drive(32'h0000_0100, 0, 2, 0, 1);
    check("R7 clear 1E988", ram_we, 1);
    ctl_store(32'hFFFE0130, 32'h804, 2);
    drive(32'h0000_0000, 0, 2, 0, 1);
    check("R6 set 804 blocks", ram_we, 0);
    ctl_store(32'hFFFE0130, 32'h0, 2);
    drive(32'h0000_0000, 0, 2, 0, 1);
    check("R7 clear 0", ram_we, 1);
    ctl_store(32'hFFFE0130, 32'h800, 2);
    drive(32'h0, 0, 2, 0, 0);
    rst_n = 0; #2; rst_n = 1;
    drive(32'h0000_0000, 0, 2, 0, 1);
    check("R9 reset clears", ram_we, 1);
  endtask

  task automatic t_unmapped;
    drive(32'h5000_0000, 0, 2, 0, 1);
    check("R10 flag", unmapped, 1);
    check("R10 sel", sel, 0);
    check("R10 no we", ram_we, 0);
    drive(32'h5000_0000, 0, 2, 0, 0);
    check("R10 flag drops", unmapped, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_idle_and_reset();
    t_ram();
    t_rom_io();
    t_guard();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule